// File: doc/BRIEF.md
# Time-Multiplexed Torus Neighbour Fabric

This block carries the neighbour traffic of one physical mesh router that is time-shared across `GRID_W × GRID_H` virtual routers. The virtual routers are visited in ascending index order, and index 0 is the upper-left node. Rows are filled left to right, so a node at row `r` and column `c` has index `r*GRID_W + c`.

During one model cycle the router emits, for each instance in turn, a token with four directional lanes (east, west, north, south). The fabric writes every lane into the input slot that the receiving neighbour will read in the next model cycle, on the side that faces the sender. When the router asks for the next model cycle's inputs, the fabric hands them back in the same ascending order.

East and west neighbours are found by stepping one column within the row, wrapping around inside that row. North and south neighbours are found by stepping a whole row width through the full instance count, wrapping from the top row to the bottom row and back.

A mode bit lets the same fabric model a grid that does not wrap. In that mode the lanes leaving the grid's border are replaced by NoMessage (`has = 0`, data zero) at capture time. The routes themselves do not change.

A sequencer with three states controls delivery:

- `ST_PRIME` runs after reset. It delivers the model-cycle-0 inputs, which are all NoMessage. After the last slot is accepted it moves to `ST_WAIT`.
- `ST_WAIT` holds delivery off until all outputs of the current model cycle have been captured. It then moves to `ST_DRAIN`.
- `ST_DRAIN` streams the captured inputs in index order. After the last slot it returns to `ST_WAIT`.

Top module: `torus_perm_fabric`

## Requirements
- R1: While reset is held and for the first N slots after reset, the fabric offers `dlv_valid = 1` with indices 0..N-1 in order. Every one of these slots has `dlv_has = 0` and zero data.
- R2: Deliveries of one model cycle carry indices 0..N-1 in ascending order, and one slot advances per cycle in which `dlv_valid` and `dlv_ready` are both high. While `dlv_ready` is low, the index, the lane flags and the lane data stay constant.
- R3: The east lane (lane 0, bits [DW-1:0], flag bit 0) of instance `r*W+c` arrives as the west-side input (lane 1) of instance `r*W + (c+1) mod W` in the next model cycle.
- R4: The west lane (lane 1, bits [2*DW-1:DW], flag bit 1) of instance `r*W+c` arrives as the east-side input (lane 0) of instance `r*W + (c-1) mod W`.
- R5: The north lane (lane 2, flag bit 2) of instance `x` arrives as the south-side input (lane 3) of instance `(x - W) mod N`.
- R6: The south lane (lane 3, flag bit 3) of instance `x` arrives as the north-side input (lane 2) of instance `(x + W) mod N`.
- R7: The inputs of a model cycle are not offered until all N tokens of the previous model cycle have been captured. After the last slot of a model cycle is accepted, `dlv_valid` is low in the following cycle.
- R8: With `grid_mode = 1` on a token, the following lanes arrive with `has = 0` and zero data: its east lane if `c = W-1`, its west lane if `c = 0`, its north lane if `r = 0`, and its south lane if `r = H-1`. Its other lanes are delivered unchanged.
- R9: With `grid_mode = 0`, lanes that cross the border wrap around and keep their flag and data.
- R10: `grid_mode` is sampled per token at capture, so tokens of one model cycle may mix the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grid_mode | input | 1 | 1 = non-wrapping grid masking for the token being captured |
| tok_valid | input | 1 | Router output token present this cycle |
| tok_idx | input | IDX_W | Source instance of the token, ascending per model cycle |
| tok_has | input | 4 | Per-lane message-present flags (bit k = lane k) |
| tok_data | input | 4*DATA_W | Lane payloads, lane k at bits k*DATA_W +: DATA_W |
| dlv_ready | input | 1 | Router accepts the offered input slot |
| dlv_valid | output | 1 | Input slot offered |
| dlv_idx | output | IDX_W | Destination instance of the offered slot |
| dlv_has | output | 4 | Per-side flags; side k receives from the neighbour in direction k |
| dlv_data | output | 4*DATA_W | Side payloads, same layout as `tok_data` |

## Verification
A wrong route or a wrong destination index shows up on the very next drain. The affected payload appears on the wrong side or at the wrong instance, while the intended slot shows stale or foreign data. A comparison against a receiver-side neighbour model catches this within one model cycle.

A stuck bank pointer or a miscounted capture shows one of two symptoms: the fabric replays the previous model cycle's data, or it offers a slot before the last token of the cycle is written. The latter is visible as `dlv_valid` rising early.

Wrong masking only affects border lanes. For that reason grid, torus and mixed-mode cycles are each run with all lanes carrying distinct random data.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    localparam int NDIR = 4;

    typedef enum logic [1:0] {
        DIR_E = 2'd0,
        DIR_W = 2'd1,
        DIR_N = 2'd2,
        DIR_S = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // the input side that receives an output lane faces back toward the sender
    function automatic int facing(input int k);
        return k ^ 1;
    endfunction

endpackage

// File: rtl/tpf_route.sv
module tpf_route
    import tpf_pkg::*;
#(
    parameter int GRID_W = 4,
    parameter int GRID_H = 3,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]      src_idx,
    output logic [NDIR*IDX_W-1:0] dest_idx,
    output logic [NDIR-1:0]       at_border
);
    localparam int N = GRID_W * GRID_H;

    int row;
    int col;
    int x;

    always_comb begin
        x   = int'(src_idx);
        row = x / GRID_W;
        col = x % GRID_W;
    end

    for (genvar k = 0; k < NDIR; k++) begin : g_dir
        if (k == int'(DIR_E)) begin : g_e
            always_comb begin
                dest_idx[k*IDX_W +: IDX_W] = IDX_W'(row * GRID_W + ((col == GRID_W - 1) ? 0 : col + 1));
                at_border[k] = (col == GRID_W - 1);
            end
        end else if (k == int'(DIR_W)) begin : g_w
            always_comb begin
                dest_idx[k*IDX_W +: IDX_W] = IDX_W'(row * GRID_W + ((col == 0) ? GRID_W - 1 : col - 1));
                at_border[k] = (col == 0);
            end
        end else if (k == int'(DIR_N)) begin : g_n
            always_comb begin
                dest_idx[k*IDX_W +: IDX_W] = IDX_W'((x < GRID_W) ? x + N - GRID_W : x - GRID_W);
                at_border[k] = (row == 0);
            end
        end else begin : g_s
            always_comb begin
                dest_idx[k*IDX_W +: IDX_W] = IDX_W'((x >= N - GRID_W) ? x - (N - GRID_W) : x + GRID_W);
                at_border[k] = (row == GRID_H - 1);
            end
        end
    end

endmodule

// File: rtl/tpf_bank.sv
module tpf_bank #(
    parameter int N      = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic              wr_has,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_has,
    output logic [DATA_W-1:0] rd_data
);
    logic              has_q [2][N];
    logic [DATA_W-1:0] dat_q [2][N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < N; i++) begin
                    has_q[b][i] <= 1'b0;
                    dat_q[b][i] <= '0;
                end
            end
        end else if (wr_en) begin
            has_q[wr_bank][wr_addr] <= wr_has;
            dat_q[wr_bank][wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_has  = has_q[rd_bank][rd_addr];
        rd_data = dat_q[rd_bank][rd_addr];
    end

endmodule

// File: rtl/tpf_seq.sv
module tpf_seq
    import tpf_pkg::*;
#(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic             dlv_ready,
    output logic             wr_bank,
    output logic             rd_bank,
    output logic [IDX_W-1:0] rd_idx,
    output logic             dlv_valid,
    output logic             priming
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] wr_cnt_q;
    logic             pend_q;
    logic             fire, last_slot, cap_done, drain_done;

    always_comb begin
        fire       = dlv_valid && dlv_ready;
        last_slot  = fire && (rd_idx == LAST);
        cap_done   = tok_valid && (wr_cnt_q == LAST);
        drain_done = last_slot && (state_q == ST_DRAIN);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (last_slot) state_d = ST_WAIT;
            ST_WAIT:  if (pend_q)    state_d = ST_DRAIN;
            ST_DRAIN: if (last_slot) state_d = ST_WAIT;
            default:                 state_d = ST_PRIME;
        endcase
    end

    // outputs
    always_comb begin
        dlv_valid = 1'b0;
        priming   = 1'b0;
        unique case (state_q)
            ST_PRIME: begin dlv_valid = 1'b1; priming = 1'b1; end
            ST_WAIT:  dlv_valid = 1'b0;
            ST_DRAIN: dlv_valid = 1'b1;
            default:  dlv_valid = 1'b0;
        endcase
    end

    // capture side: counts one model cycle of tokens, then swaps banks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
            wr_bank  <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (tok_valid) begin
                if (cap_done) begin
                    wr_cnt_q <= '0;
                    wr_bank  <= ~wr_bank;
                end else begin
                    wr_cnt_q <= wr_cnt_q + 1'b1;
                end
            end
            pend_q <= (pend_q && !drain_done) || cap_done;
        end
    end

    // delivery side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            rd_bank <= 1'b0;
        end else begin
            if (fire) rd_idx <= last_slot ? '0 : rd_idx + 1'b1;
            if (drain_done) rd_bank <= ~rd_bank;
        end
    end

endmodule

// File: rtl/torus_perm_fabric.sv
module torus_perm_fabric
    import tpf_pkg::*;
#(
    parameter int GRID_W = 4,
    parameter int GRID_H = 3,
    parameter int DATA_W = 8,
    localparam int N     = GRID_W * GRID_H,
    localparam int IDX_W = (N > 2) ? $clog2(N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   grid_mode,
    input  logic                   tok_valid,
    input  logic [IDX_W-1:0]       tok_idx,
    input  logic [3:0]             tok_has,
    input  logic [4*DATA_W-1:0]    tok_data,
    input  logic                   dlv_ready,
    output logic                   dlv_valid,
    output logic [IDX_W-1:0]       dlv_idx,
    output logic [3:0]             dlv_has,
    output logic [4*DATA_W-1:0]    dlv_data
);
    logic [NDIR*IDX_W-1:0]  dest;
    logic [NDIR-1:0]        border;
    logic [NDIR-1:0]        has_m;
    logic [NDIR*DATA_W-1:0] dat_m;
    logic                   wr_bank, rd_bank, priming;
    logic [IDX_W-1:0]       rd_idx;
    logic [NDIR-1:0]        bank_has;
    logic [NDIR*DATA_W-1:0] bank_dat;

    tpf_route #(.GRID_W(GRID_W), .GRID_H(GRID_H), .IDX_W(IDX_W)) u_route (
        .src_idx   (tok_idx),
        .dest_idx  (dest),
        .at_border (border)
    );

    tpf_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .dlv_ready (dlv_ready),
        .wr_bank   (wr_bank),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .dlv_valid (dlv_valid),
        .priming   (priming)
    );

    // grid masking on the capture side
    for (genvar k = 0; k < NDIR; k++) begin : g_mask
        always_comb begin
            has_m[k] = tok_has[k] && !(grid_mode && border[k]);
            dat_m[k*DATA_W +: DATA_W] = has_m[k] ? tok_data[k*DATA_W +: DATA_W] : '0;
        end
    end

    // bank j holds input side j; it is fed by output lane facing(j) of the sender
    for (genvar j = 0; j < NDIR; j++) begin : g_bank
        localparam int SRC = facing(j);
        tpf_bank #(.N(N), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tok_valid),
            .wr_bank (wr_bank),
            .wr_addr (dest[SRC*IDX_W +: IDX_W]),
            .wr_has  (has_m[SRC]),
            .wr_data (dat_m[SRC*DATA_W +: DATA_W]),
            .rd_bank (rd_bank),
            .rd_addr (rd_idx),
            .rd_has  (bank_has[j]),
            .rd_data (bank_dat[j*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        dlv_idx  = rd_idx;
        dlv_has  = priming ? '0 : bank_has;
        dlv_data = priming ? '0 : bank_dat;
    end

endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
    parameter int N      = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dlv_ready,
    input logic                dlv_valid,
    input logic [IDX_W-1:0]    dlv_idx,
    input logic [3:0]          dlv_has,
    input logic [4*DATA_W-1:0] dlv_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && dlv_idx != LAST) |=>
            (dlv_valid && dlv_idx == IDX_W'($past(dlv_idx) + 1'b1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=>
            (dlv_valid && $stable(dlv_idx) && $stable(dlv_has) && $stable(dlv_data)));

    p_gap_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && dlv_idx == LAST) |=> !dlv_valid);

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_idx <= LAST));

endmodule

bind torus_perm_fabric tpf_checker #(.N(N), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_tpf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .dlv_ready (dlv_ready),
    .dlv_valid (dlv_valid),
    .dlv_idx   (dlv_idx),
    .dlv_has   (dlv_has),
    .dlv_data  (dlv_data)
);

// File: tb/tb_torus_perm_fabric.sv
module tb_torus_perm_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 4;
    localparam int GH = 3;
    localparam int DW = 8;
    localparam int N  = GW * GH;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grid_mode = 1'b0;
    logic          tok_valid = 1'b0;
    logic [IW-1:0] tok_idx = '0;
    logic [3:0]    tok_has = '0;
    logic [4*DW-1:0] tok_data = '0;
    logic          dlv_ready = 1'b0;
    logic          dlv_valid;
    logic [IW-1:0] dlv_idx;
    logic [3:0]    dlv_has;
    logic [4*DW-1:0] dlv_data;

    torus_perm_fabric #(.GRID_W(GW), .GRID_H(GH), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .grid_mode(grid_mode),
        .tok_valid(tok_valid), .tok_idx(tok_idx), .tok_has(tok_has), .tok_data(tok_data),
        .dlv_ready(dlv_ready), .dlv_valid(dlv_valid), .dlv_idx(dlv_idx),
        .dlv_has(dlv_has), .dlv_data(dlv_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int              idx;
        logic [3:0]      has;
        logic [4*DW-1:0] data;
        string           tag [4];
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    logic [3:0]    s_has [N];
    logic [DW-1:0] s_dat [N][4];
    bit            s_grid [N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dlv_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "delivery with nothing expected", longint'(dlv_idx), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(dlv_idx) == e.idx, "R2", "slot index", longint'(dlv_idx), longint'(e.idx));
                for (int k = 0; k < 4; k++) begin
                    check(dlv_has[k] == e.has[k], e.tag[k], $sformatf("flag side %0d idx %0d", k, e.idx),
                          longint'(dlv_has[k]), longint'(e.has[k]));
                    check(dlv_data[k*DW +: DW] == e.data[k*DW +: DW], e.tag[k],
                          $sformatf("data side %0d idx %0d", k, e.idx),
                          longint'(dlv_data[k*DW +: DW]), longint'(e.data[k*DW +: DW]));
                end
            end
        end
    end

    // receiver-side 2D neighbour model; mode: 0 torus, 1 grid, 2 mixed
    task automatic build_expected(input int mode);
        for (int d = 0; d < N; d++) begin
            exp_t e;
            int r, c;
            r = d / GW;
            c = d % GW;
            e.idx = d;
            for (int k = 0; k < 4; k++) begin
                int src, lane;
                bit exists, arrive;
                string lane_req;
                case (k)
                    0: begin src = r*GW + (c+1)%GW;        lane = 1; exists = (c != GW-1); lane_req = "R4"; end
                    1: begin src = r*GW + (c+GW-1)%GW;     lane = 0; exists = (c != 0);    lane_req = "R3"; end
                    2: begin src = ((r+GH-1)%GH)*GW + c;   lane = 3; exists = (r != 0);    lane_req = "R6"; end
                    default: begin src = ((r+1)%GH)*GW + c; lane = 2; exists = (r != GH-1); lane_req = "R5"; end
                endcase
                arrive = exists || !s_grid[src];
                e.has[k] = arrive && s_has[src][lane];
                e.data[k*DW +: DW] = e.has[k] ? s_dat[src][lane] : '0;
                if (mode == 2)     e.tag[k] = "R10";
                else if (!exists)  e.tag[k] = (mode == 1) ? "R8" : "R9";
                else               e.tag[k] = lane_req;
            end
            q.push_back(e);
        end
    endtask

    task automatic wait_empty();
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic model_cycle(input int mode, input bit stall);
        for (int x = 0; x < N; x++) begin
            s_grid[x] = (mode == 2) ? bit'($urandom % 2) : (mode == 1);
            for (int k = 0; k < 4; k++) begin
                s_has[x][k] = ($urandom % 8) != 0;
                s_dat[x][k] = DW'($urandom);
            end
        end
        build_expected(mode);
        if (stall) dlv_ready = 1'b0;
        for (int x = 0; x < N; x++) begin
            @(posedge clk); #1;
            if (x == N - 1)
                check(dlv_valid == 1'b0, "R7", "slot offered before cycle captured",
                      longint'(dlv_valid), 0);
            tok_valid = 1'b1;
            tok_idx   = IW'(x);
            grid_mode = s_grid[x];
            for (int k = 0; k < 4; k++) begin
                tok_has[k] = s_has[x][k];
                tok_data[k*DW +: DW] = s_has[x][k] ? s_dat[x][k] : DW'($urandom);
            end
        end
        @(posedge clk); #1;
        tok_valid = 1'b0;
        if (stall) begin
            logic [IW-1:0]   i0;
            logic [3:0]      h0;
            logic [4*DW-1:0] d0;
            repeat (2) @(posedge clk);
            #1;
            i0 = dlv_idx; h0 = dlv_has; d0 = dlv_data;
            check(dlv_valid == 1'b1, "R2", "offer while stalled", longint'(dlv_valid), 1);
            check(i0 == '0, "R2", "first slot index", longint'(i0), 0);
            repeat (3) @(posedge clk);
            #1;
            check(dlv_idx == i0 && dlv_has == h0 && dlv_data == d0, "R2", "hold under stall",
                  longint'(dlv_data), longint'(d0));
            dlv_ready = 1'b1;
        end
        wait_empty();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dlv_valid == 1'b1 && dlv_idx == '0 && dlv_has == '0 && dlv_data == '0,
              "R1", "reset offer", longint'({dlv_valid, dlv_has}), 64'h10);
        // priming slots of model cycle 0
        for (int d = 0; d < N; d++) begin
            exp_t e;
            e.idx = d; e.has = '0; e.data = '0;
            for (int k = 0; k < 4; k++) e.tag[k] = "R1";
            q.push_back(e);
        end
        rst_n = 1'b1;
        dlv_ready = 1'b1;
        wait_empty();
        check(dlv_valid == 1'b0, "R7", "idle after priming", longint'(dlv_valid), 0);

        model_cycle(0, 1'b0);
        model_cycle(0, 1'b1);
        model_cycle(1, 1'b0);
        model_cycle(1, 1'b0);
        model_cycle(0, 1'b0);
        model_cycle(2, 1'b0);
        model_cycle(2, 1'b1);
        model_cycle(1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule